// File: doc/BRIEF.md
# Data-Strobe Character Framer

This block sits behind the two receive wires of a data-strobe serial link, the encoding used by SpaceWire. On such a link exactly one of the two wires changes level for each bit, so the XOR of the wires toggles once per bit. A system clock much faster than the bit rate samples both wires through synchronizers. Every change of the XOR is taken as one new bit, whichever direction it goes, and so bits of both phases of the recovered clock land in one shared 5-bit counter.

The framer groups bits into characters. Each character opens with a parity bit, then a flag that tells a short control character from a data character. A control character carries two code bits and is 4 bits long. A data character carries eight payload bits and is 10 bits long. When the last bit has arrived the framer raises `char_valid` for one cycle and presents the decoded fields with it. It also reports an odd-parity failure. The parity rule spans the payload of the character before, plus the parity and flag bits of the current one.

The framer is a four-state machine. HUNT waits after reset for the first rising Data transition. PARITY takes the first bit of a character. FLAG takes the type bit. PAYLOAD shifts in code or data bits. Its transitions are: HUNT→FLAG on a bit whose Data line rose, PARITY→FLAG on any bit, FLAG→PAYLOAD on any bit, PAYLOAD→PARITY on the last bit of the character, and PAYLOAD→PAYLOAD on the other payload bits. All counting lives in clocked registers. No counter value loops back on itself through logic alone.

Top module: `ds_char_framer`

## Requirements
- R1: Each change in the level of (Data XOR Strobe) seen after the synchronizers counts as exactly one received bit. A Data toggle and a Strobe toggle count the same way, and the value of the bit is the Data level.
- R2: After reset the framer stays in HUNT and does not count bits until a bit arrives on which Data rose from 0 to 1. Bits before that, carried by Strobe toggles, give no output. The rising bit itself is the parity bit of the first character.
- R3: Bit 0 of a character is its parity bit and is echoed on `parity_bit` with the character. Bit 1 is the control flag: 1 means control, 0 means data.
- R4: With the flag set, the bit counter returns to 0 after count value 3 (4 bits). The character comes out with `is_control`=1, with `ctrl_code` bit 0 = the first payload bit and bit 1 = the second, and with `data_byte`=0.
- R5: With the flag clear, the bit counter returns to 0 after count value 9 (10 bits). The character comes out with `is_control`=0 and `data_byte` filled least significant bit first, in arrival order, and with `ctrl_code`=0.
- R6: `char_valid` is high for exactly one cycle per completed character and never in two cycles in a row.
- R7: The number of ones in the previous character's payload, plus this character's parity bit, plus its flag bit, must be odd. If it is even, `parity_error` is high in the same cycle as this character's `char_valid`, and low at all other times. The payload before the first character after reset counts as all zeros.
- R8: Active-low `rst_n` clears the state (to HUNT), the bit counter, all outputs and the stored payload parity. A character cut off by reset is never output.
- R9: The bit counter is 5 bits wide and is a registered counter. It only moves on a received bit while the framer is not in HUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, at least 4x the bit rate |
| rst_n | input | 1 | Active-low receive reset |
| ds_data_in | input | 1 | Data wire of the link, asynchronous |
| ds_strobe_in | input | 1 | Strobe wire of the link, asynchronous |
| char_valid | output | 1 | One-cycle pulse: a character is complete |
| is_control | output | 1 | 1 = control character, 0 = data character |
| ctrl_code | output | 2 | Control code, first received bit in bit 0 |
| data_byte | output | 8 | Data payload, first received bit in bit 0 |
| parity_bit | output | 1 | Parity bit received with this character |
| parity_error | output | 1 | Odd-parity failure for this character |

## Verification
The assertions check on every cycle the properties that hold at any instant. HUNT keeps the counter at zero. The counter wraps to zero, and `char_valid` follows, right after count 3 for a control character and count 9 for a data character. The completion pulse never lasts two cycles. `parity_error` only appears together with `char_valid`. What the assertions cannot show is that the decoded fields are right. Only the bench's scenarios can show that bytes and codes are rebuilt in least-significant-first order, that runs of equal bits carried by Strobe are counted like Data toggles, that parity is chained across characters, that bits before the first rising Data edge are ignored, and that a character cut off by reset leaves no trace.

// File: rtl/ds_framer_pkg.sv
package ds_framer_pkg;

    // bit counter width and wrap points
    localparam int CNT_W      = 5;
    localparam int CTRL_LEN   = 4;
    localparam int DATA_LEN   = 10;
    localparam int CTRL_LAST  = CTRL_LEN - 1;
    localparam int DATA_LAST  = DATA_LEN - 1;
    localparam int HDR_BITS   = 2;
    localparam int BYTE_W     = DATA_LEN - HDR_BITS;
    localparam int CODE_W     = CTRL_LEN - HDR_BITS;

    typedef enum logic [1:0] {
        S_HUNT    = 2'd0,
        S_PARITY  = 2'd1,
        S_FLAG    = 2'd2,
        S_PAYLOAD = 2'd3
    } fr_state_t;

endpackage

// File: rtl/ds_edge_detect.sv
module ds_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    input  logic strobe_in,
    output logic bit_evt,
    output logic bit_val,
    output logic data_rise
);
    logic [SYNC_STAGES-1:0] d_sync;
    logic [SYNC_STAGES-1:0] s_sync;
    logic                   xor_prev;
    logic                   d_prev;
    logic                   d_now;
    logic                   s_now;

    // synchronizer chains, one per wire
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        d_sync[0] <= 1'b0;
                        s_sync[0] <= 1'b0;
                    end else begin
                        d_sync[0] <= data_in;
                        s_sync[0] <= strobe_in;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        d_sync[g] <= 1'b0;
                        s_sync[g] <= 1'b0;
                    end else begin
                        d_sync[g] <= d_sync[g-1];
                        s_sync[g] <= s_sync[g-1];
                    end
                end
            end
        end
    endgenerate

    assign d_now = d_sync[SYNC_STAGES-1];
    assign s_now = s_sync[SYNC_STAGES-1];

    // previous levels, registered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xor_prev <= 1'b0;
            d_prev   <= 1'b0;
        end else begin
            xor_prev <= d_now ^ s_now;
            d_prev   <= d_now;
        end
    end

    assign bit_evt   = (d_now ^ s_now) != xor_prev;
    assign bit_val   = d_now;
    assign data_rise = d_now & ~d_prev;

    // R1
    evt_has_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_evt |-> (d_now != d_prev) || (s_now != $past(s_now)));

endmodule

// File: rtl/ds_shift_reg.sv
module ds_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] sh_next
);
    logic [W-1:0] sh_q;

    // new bits enter at the top and move down, so the first one ends lowest
    always_comb begin
        if (clr)
            sh_next = '0;
        else if (shift)
            sh_next = {bit_in, sh_q[W-1:1]};
        else
            sh_next = sh_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= sh_next;
    end

endmodule

// File: rtl/ds_parity_track.sv
module ds_parity_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic flag_take,
    input  logic pay_take,
    input  logic char_done,
    input  logic bit_in,
    output logic par_bad
);
    logic prev_pay;
    logic pay_x;
    logic acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_pay <= 1'b0;
            pay_x    <= 1'b0;
            acc      <= 1'b0;
        end else begin
            if (start) begin
                acc   <= prev_pay ^ bit_in;
                pay_x <= 1'b0;
            end
            if (flag_take)
                acc <= acc ^ bit_in;
            if (pay_take)
                pay_x <= pay_x ^ bit_in;
            if (char_done)
                prev_pay <= pay_x ^ bit_in;
        end
    end

    // odd total required; even means failure
    assign par_bad = ~acc;

endmodule

// File: rtl/ds_frame_fsm.sv
module ds_frame_fsm
    import ds_framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_evt,
    input  logic              bit_val,
    input  logic              data_rise,
    input  logic [BYTE_W-1:0] sh_next,
    input  logic              par_bad,
    output logic              start,
    output logic              flag_take,
    output logic              pay_take,
    output logic              char_done,
    output logic              char_valid,
    output logic              is_control,
    output logic [CODE_W-1:0] ctrl_code,
    output logic [BYTE_W-1:0] data_byte,
    output logic              parity_bit,
    output logic              parity_error
);
    fr_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             par_q;
    logic             is_last;

    assign is_last = (flag_q && cnt_q == CNT_W'(CTRL_LAST)) ||
                     (cnt_q == CNT_W'(DATA_LAST));

    // next state and strobes to the helpers
    always_comb begin
        state_d   = state_q;
        start     = 1'b0;
        flag_take = 1'b0;
        pay_take  = 1'b0;
        char_done = 1'b0;
        unique case (state_q)
            S_HUNT: begin
                if (bit_evt && data_rise) begin
                    start   = 1'b1;
                    state_d = S_FLAG;
                end
            end
            S_PARITY: begin
                if (bit_evt) begin
                    start   = 1'b1;
                    state_d = S_FLAG;
                end
            end
            S_FLAG: begin
                if (bit_evt) begin
                    flag_take = 1'b1;
                    state_d   = S_PAYLOAD;
                end
            end
            S_PAYLOAD: begin
                if (bit_evt) begin
                    pay_take = 1'b1;
                    if (is_last) begin
                        char_done = 1'b1;
                        state_d   = S_PARITY;
                    end
                end
            end
            default: state_d = S_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_HUNT;
        else
            state_q <= state_d;
    end

    // registered bit counter, shared by both link phases
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (char_done)
            cnt_q <= '0;
        else if (start || flag_take || pay_take)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // header capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            par_q  <= 1'b0;
        end else begin
            if (start)
                par_q <= bit_val;
            if (flag_take)
                flag_q <= bit_val;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_valid   <= 1'b0;
            is_control   <= 1'b0;
            ctrl_code    <= '0;
            data_byte    <= '0;
            parity_bit   <= 1'b0;
            parity_error <= 1'b0;
        end else begin
            char_valid   <= char_done;
            parity_error <= char_done & par_bad;
            if (char_done) begin
                is_control <= flag_q;
                parity_bit <= par_q;
                ctrl_code  <= flag_q ? sh_next[BYTE_W-1 -: CODE_W] : '0;
                data_byte  <= flag_q ? '0 : sh_next;
            end
        end
    end

    // R2
    hunt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HUNT) |-> (cnt_q == '0));

    // R4
    ctrl_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_evt && state_q == S_PAYLOAD && flag_q && cnt_q == CNT_W'(CTRL_LAST))
        |=> (cnt_q == '0 && char_valid && is_control));

    // R5
    data_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_evt && state_q == S_PAYLOAD && !flag_q && cnt_q == CNT_W'(DATA_LAST))
        |=> (cnt_q == '0 && char_valid && !is_control));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    // R7
    perr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parity_error |-> char_valid);

    // R9
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_evt) |=> $stable(cnt_q));

endmodule

// File: rtl/ds_char_framer.sv
module ds_char_framer
    import ds_framer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ds_data_in,
    input  logic              ds_strobe_in,
    output logic              char_valid,
    output logic              is_control,
    output logic [CODE_W-1:0] ctrl_code,
    output logic [BYTE_W-1:0] data_byte,
    output logic              parity_bit,
    output logic              parity_error
);
    logic              bit_evt;
    logic              bit_val;
    logic              data_rise;
    logic              start;
    logic              flag_take;
    logic              pay_take;
    logic              char_done;
    logic              par_bad;
    logic [BYTE_W-1:0] sh_next;

    ds_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (ds_data_in),
        .strobe_in (ds_strobe_in),
        .bit_evt   (bit_evt),
        .bit_val   (bit_val),
        .data_rise (data_rise)
    );

    ds_shift_reg #(.W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .shift   (pay_take),
        .bit_in  (bit_val),
        .sh_next (sh_next)
    );

    ds_parity_track u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .flag_take (flag_take),
        .pay_take  (pay_take),
        .char_done (char_done),
        .bit_in    (bit_val),
        .par_bad   (par_bad)
    );

    ds_frame_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_evt      (bit_evt),
        .bit_val      (bit_val),
        .data_rise    (data_rise),
        .sh_next      (sh_next),
        .par_bad      (par_bad),
        .start        (start),
        .flag_take    (flag_take),
        .pay_take     (pay_take),
        .char_done    (char_done),
        .char_valid   (char_valid),
        .is_control   (is_control),
        .ctrl_code    (ctrl_code),
        .data_byte    (data_byte),
        .parity_bit   (parity_bit),
        .parity_error (parity_error)
    );

endmodule

// File: tb/ds_char_framer_tb.sv
module ds_char_framer_tb;

    localparam int BIT_CYC = 6;

    typedef struct packed {
        logic       ctrl;
        logic [1:0] code;
        logic [7:0] data;
        logic       par;
        logic       perr;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       d_line = 1'b0;
    logic       s_line = 1'b0;
    logic       char_valid;
    logic       is_control;
    logic [1:0] ctrl_code;
    logic [7:0] data_byte;
    logic       parity_bit;
    logic       parity_error;

    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    logic prev_pay = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    ds_char_framer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ds_data_in   (d_line),
        .ds_strobe_in (s_line),
        .char_valid   (char_valid),
        .is_control   (is_control),
        .ctrl_code    (ctrl_code),
        .data_byte    (data_byte),
        .parity_bit   (parity_bit),
        .parity_error (parity_error)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one bit on the wires: Data carries the value, Strobe toggles on repeats (R1)
    task automatic send_bit(input logic b);
        @(negedge clk);
        if (b != d_line) d_line = b;
        else             s_line = ~s_line;
        repeat (BIT_CYC - 1) @(negedge clk);
    endtask

    task automatic send_char(input logic ctrl, input logic [7:0] pay, input bit bad_par);
        exp_t e;
        logic p;
        logic px;
        int   n;
        n  = ctrl ? 2 : 8;
        px = 1'b0;
        for (int i = 0; i < n; i++) px ^= pay[i];
        p = 1'b1 ^ prev_pay ^ ctrl;
        if (bad_par) p = ~p;
        e.ctrl = ctrl;
        e.code = ctrl ? pay[1:0] : 2'b00;
        e.data = ctrl ? 8'h00 : pay;
        e.par  = p;
        e.perr = bad_par;
        exp_q.push_back(e);
        send_bit(p);
        send_bit(ctrl);
        for (int i = 0; i < n; i++) send_bit(pay[i]);
        prev_pay = px;
    endtask

    task automatic check_idle_outputs(input string tag);
        check(char_valid == 1'b0 && is_control == 1'b0 && ctrl_code == 2'b00 &&
              data_byte == 8'h00 && parity_bit == 1'b0 && parity_error == 1'b0,
              tag, {char_valid, is_control, ctrl_code, data_byte, parity_bit, parity_error}, 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && char_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R6 unexpected char_valid", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(is_control == e.ctrl, "R3 flag", is_control, e.ctrl);
                if (e.ctrl) begin
                    check(ctrl_code == e.code, "R4 ctrl_code", ctrl_code, e.code);
                    check(data_byte == 8'h00, "R4 data_byte zero", data_byte, 0);
                end else begin
                    check(data_byte == e.data, "R5 data_byte", data_byte, e.data);
                    check(ctrl_code == 2'b00, "R5 ctrl_code zero", ctrl_code, 0);
                end
                check(parity_bit == e.par, "R3 parity_bit", parity_bit, e.par);
                check(parity_error == e.perr, "R7 parity_error", parity_error, e.perr);
            end
        end
        if (rst_n && parity_error && !char_valid)
            check(1'b0, "R7 parity_error without char_valid", 1, 0);
    end

    initial begin
        repeat (5) @(negedge clk);
        check_idle_outputs("R8 reset state");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_idle_outputs("R8 after release");

        // R2: zero bits ride on Strobe toggles before framing starts
        send_bit(1'b0);
        send_bit(1'b0);
        send_bit(1'b0);
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R2 nothing framed during hunt", exp_q.size(), 0);

        // first character: parity 1 gives the rising Data edge
        send_char(1'b0, 8'hA5, 1'b0);
        send_char(1'b1, 8'h00, 1'b0);
        send_char(1'b1, 8'h01, 1'b0);
        send_char(1'b1, 8'h02, 1'b0);
        send_char(1'b1, 8'h03, 1'b0);
        send_char(1'b0, 8'h00, 1'b0);
        send_char(1'b0, 8'hFF, 1'b0);
        send_char(1'b0, 8'h5A, 1'b1);
        send_char(1'b1, 8'h01, 1'b1);
        send_char(1'b0, 8'h81, 1'b0);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R6 all characters delivered", exp_q.size(), 0);

        // R8: partial character then reset
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        @(negedge clk);
        rst_n  = 1'b0;
        d_line = 1'b0;
        s_line = 1'b0;
        prev_pay = 1'b0;
        repeat (4) @(negedge clk);
        check_idle_outputs("R8 mid-character reset");
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check_idle_outputs("R8 no output from cut character");

        send_char(1'b0, 8'h3C, 1'b0);
        send_char(1'b1, 8'h02, 1'b0);
        send_char(1'b0, 8'h7E, 1'b0);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R6 delivered after reset", exp_q.size(), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule